// File: doc/BRIEF.md
# Edge delay event scheduler

The block schedules timing edges for one digital tester pin. It runs on a 100 MHz master clock, and each clock is one base period of 10 ns. At a cycle start, while the pattern-valid input is high, it takes three inputs: a 22-bit edge delay, a 4-bit event code and an 8-bit offset that every edge shares. It adds the offset to the delay. The low 8 bits of that sum are a fine code in steps of 1/256 of a period (about 39 ps), meant for an external analog vernier. The remaining upper bits are a count of whole clock periods.

A delay can reach well past the cycle in which it was issued. Edges issued in several successive cycles can therefore be waiting at the same time. The scheduler keeps them in a small queue, oldest first, and counts each one down on its own. When an edge's coarse count runs out, the block gives a one-clock fire pulse together with that edge's fine code and event code. Only one edge can leave per clock. When several edges are due together, the oldest goes first. An edge that arrives when the queue has no room is lost, and a sticky flag records the loss.

Top module: `edge_sched`

## Requirements
- R1: While reset is high and just after it, fire_o, fine_o, evt_code_o and overflow_o are all 0.
- R2: The scheduled time is sum = delay_i + offset_i, computed 23 bits wide with no wrap. fine_o carries sum[7:0], and the coarse count is sum[22:8]. Even the largest delay plus the largest offset (0x3FFFFF + 0xFF) fires after 0x4000 periods with fine code 0xFE.
- R3: An event is accepted at clock edge A and has coarse count c. When no older event is due at the same time, fire_o is high for exactly one clock, in the cycle that follows edge A + c + 1.
- R4: The fire pulse carries the accepted 4-bit event code unchanged. This holds for all 16 code values 0..15.
- R5: While fire_o is low, fine_o and evt_code_o are 0.
- R6: Up to 4 events can be pending at once. Each one counts down on its own, so an event issued later with a shorter delay fires before one issued earlier.
- R7: When more than one pending event is due in the same clock, the oldest accepted event fires. Each of the others waits one more clock per event ahead of it, and they keep their arrival order.
- R8: When pat_vld_i is low, nothing is accepted: delay_i, evt_code_i and offset_i have no effect and produce no fire.
- R9: An event that arrives while 4 events stay pending after that edge is dropped and never fires. The drop sets overflow_o, which stays high until reset.
- R10: A slot that is freed by a fire on the same clock edge is given to the event arriving on that edge.
- R11: Each accepted event produces exactly one fire pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_vld_i | input | 1 | Pattern data valid; an event is offered on this clock |
| delay_i | input | 22 | Edge delay from the cycle start, in 1/256-period steps |
| evt_code_i | input | 4 | Event code of the edge |
| offset_i | input | 8 | Shared offset added to every delay |
| fire_o | output | 1 | One-clock pulse when an edge is emitted |
| fine_o | output | 8 | Vernier fine code of the emitted edge |
| evt_code_o | output | 4 | Event code of the emitted edge |
| overflow_o | output | 1 | Sticky: an event was dropped because the queue was full |

## Verification
Two kinds of clash can happen in the same clock. First, two or more pending edges can reach zero together. The bench provokes this by issuing an edge with a longer delay, then one with a shorter delay a cycle later, so that both land on the same clock. It judges the result by the order and the exact cycle of the fire pulses. Second, an arrival can come at the same edge as a fire while the queue is full. The bench fills the queue so that its oldest entry retires on exactly the edge where a fifth event arrives: that event must be kept and must fire later. The next arrival, with nothing retiring, must be lost and must raise the overflow flag.

// File: rtl/edge_sched_pkg.sv
package edge_sched_pkg;

    localparam int DLY_W  = 22;
    localparam int OFS_W  = 8;
    localparam int FINE_W = 8;
    localparam int CODE_W = 4;
    localparam int SUM_W  = DLY_W + 1;
    localparam int CRS_W  = SUM_W - FINE_W;

    typedef logic [CRS_W-1:0]  crs_t;
    typedef logic [FINE_W-1:0] fine_t;
    typedef logic [CODE_W-1:0] code_t;

    // one pending edge
    typedef struct packed {
        crs_t  cnt;
        fine_t fine;
        code_t code;
    } pend_t;

    typedef struct packed {
        crs_t  coarse;
        fine_t fine;
    } split_t;

    // delay plus shared offset, split into whole periods and vernier fraction
    function automatic split_t split_delay(input logic [DLY_W-1:0] dly,
                                           input logic [OFS_W-1:0] ofs);
        logic [SUM_W-1:0] s;
        split_t r;
        s        = SUM_W'(dly) + SUM_W'(ofs);
        r.coarse = s[SUM_W-1:FINE_W];
        r.fine   = s[FINE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/edge_sched_sum.sv
module edge_sched_sum
    import edge_sched_pkg::*;
(
    input  logic             vld_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [OFS_W-1:0] offset_i,
    input  code_t            code_i,
    output logic             push_o,
    output pend_t            ent_o
);

    split_t sp;

    always_comb begin
        sp         = split_delay(delay_i, offset_i);
        push_o     = vld_i;
        ent_o.cnt  = sp.coarse;
        ent_o.fine = sp.fine;
        ent_o.code = code_i;
    end

endmodule

// File: rtl/edge_sched_pick.sv
module edge_sched_pick
    import edge_sched_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic [DEPTH-1:0] valid_i,
    input  pend_t            ent_i [DEPTH],
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output pend_t            sel_o
);

    logic [DEPTH-1:0] due;

    for (genvar g = 0; g < DEPTH; g++) begin : g_due
        assign due[g] = valid_i[g] && (ent_i[g].cnt == '0);
    end

    // slot 0 is the oldest, so the lowest due index wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (due[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
        sel_o = ent_i[idx_o];
    end

endmodule

// File: rtl/edge_sched_queue.sv
module edge_sched_queue
    import edge_sched_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  pend_t            new_i,
    input  logic             pop_i,
    input  logic [IDX_W-1:0] pop_idx_i,
    output logic [DEPTH-1:0] valid_o,
    output pend_t            ent_o [DEPTH],
    output logic [OCC_W-1:0] occ_o,
    output logic             drop_o
);

    logic [DEPTH-1:0] v_q, v_sh, v_n;
    pend_t            e_q  [DEPTH];
    pend_t            e_sh [DEPTH];
    pend_t            e_n  [DEPTH];

    // remove the retiring entry, keeping arrival order
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int j;
            j = (i + 1 < DEPTH) ? i + 1 : i;
            if (pop_i && i >= int'(pop_idx_i)) begin
                v_sh[i] = (i + 1 < DEPTH) ? v_q[j] : 1'b0;
                e_sh[i] = e_q[j];
            end else begin
                v_sh[i] = v_q[i];
                e_sh[i] = e_q[i];
            end
        end
    end

    // count down, then append the arrival in the first free slot
    always_comb begin
        logic placed;
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            v_n[i] = v_sh[i];
            e_n[i] = e_sh[i];
            if (v_sh[i] && e_sh[i].cnt != '0)
                e_n[i].cnt = e_sh[i].cnt - CRS_W'(1);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (push_i && !placed && !v_sh[i]) begin
                v_n[i] = 1'b1;
                e_n[i] = new_i;
                placed = 1'b1;
            end
        end
        drop_o = push_i && !placed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            for (int i = 0; i < DEPTH; i++) e_q[i] <= '0;
        end else begin
            v_q <= v_n;
            for (int i = 0; i < DEPTH; i++) e_q[i] <= e_n[i];
        end
    end

    always_comb begin
        occ_o = '0;
        for (int i = 0; i < DEPTH; i++) occ_o = occ_o + OCC_W'(v_q[i]);
    end

    assign valid_o = v_q;
    assign ent_o   = e_q;

endmodule

// File: rtl/edge_sched.sv
module edge_sched
    import edge_sched_pkg::*;
#(
    parameter int DEPTH = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              pat_vld_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic              fire_o,
    output logic [FINE_W-1:0] fine_o,
    output logic [CODE_W-1:0] evt_code_o,
    output logic              overflow_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic             push;
    pend_t            new_ent;
    logic [DEPTH-1:0] q_valid;
    pend_t            q_ent [DEPTH];
    logic [OCC_W-1:0] occ;
    logic             drop;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    pend_t            hit_ent;

    edge_sched_sum u_sum (
        .vld_i    (pat_vld_i),
        .delay_i  (delay_i),
        .offset_i (offset_i),
        .code_i   (evt_code_i),
        .push_o   (push),
        .ent_o    (new_ent)
    );

    edge_sched_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push),
        .new_i     (new_ent),
        .pop_i     (hit),
        .pop_idx_i (hit_idx),
        .valid_o   (q_valid),
        .ent_o     (q_ent),
        .occ_o     (occ),
        .drop_o    (drop)
    );

    edge_sched_pick #(.DEPTH(DEPTH)) u_pick (
        .valid_i (q_valid),
        .ent_i   (q_ent),
        .hit_o   (hit),
        .idx_o   (hit_idx),
        .sel_o   (hit_ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_o     <= 1'b0;
            fine_o     <= '0;
            evt_code_o <= '0;
            overflow_o <= 1'b0;
        end else begin
            fire_o     <= hit;
            fine_o     <= hit ? hit_ent.fine : '0;
            evt_code_o <= hit ? hit_ent.code : '0;
            if (drop) overflow_o <= 1'b1;
        end
    end

endmodule

// File: rtl/edge_sched_chk.sv
module edge_sched_chk #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
)(
    input logic             clk,
    input logic             rst,
    input logic             pat_vld_i,
    input logic             fire_o,
    input logic [7:0]       fine_o,
    input logic [3:0]       evt_code_o,
    input logic             overflow_o,
    input logic [OCC_W-1:0] occ
);

    a_r5_quiet_fields: assert property (@(posedge clk) disable iff (rst)
        !fire_o |-> (fine_o == '0 && evt_code_o == '0));

    a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

    a_r8_idle_no_grow: assert property (@(posedge clk) disable iff (rst)
        !pat_vld_i |=> occ <= $past(occ));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    a_r9_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_o) |-> ($past(pat_vld_i) && int'($past(occ)) == DEPTH));

    a_r11_fire_needs_pending: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> $past(occ) != '0);

    a_r10_one_arrival: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= int'($past(occ)) + 1);

endmodule

bind edge_sched edge_sched_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pat_vld_i  (pat_vld_i),
    .fire_o     (fire_o),
    .fine_o     (fine_o),
    .evt_code_o (evt_code_o),
    .overflow_o (overflow_o),
    .occ        (occ)
);

// File: tb/edge_sched_tb.sv
module edge_sched_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pat_vld_i = 1'b0;
    logic [21:0] delay_i = '0;
    logic [3:0]  evt_code_i = '0;
    logic [7:0]  offset_i = '0;
    logic        fire_o;
    logic [7:0]  fine_o;
    logic [3:0]  evt_code_o;
    logic        overflow_o;

    always #5 clk = ~clk;

    edge_sched u_dut (
        .clk        (clk),
        .rst        (rst),
        .pat_vld_i  (pat_vld_i),
        .delay_i    (delay_i),
        .evt_code_i (evt_code_i),
        .offset_i   (offset_i),
        .fire_o     (fire_o),
        .fine_o     (fine_o),
        .evt_code_o (evt_code_o),
        .overflow_o (overflow_o)
    );

    typedef struct {
        int         due;
        logic [7:0] fine;
        logic [3:0] code;
        string      tag;
    } exp_t;

    exp_t pend[$];
    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    bit   exp_ovf = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // scoreboard monitor: the oldest due item must be on the outputs now
    always @(negedge clk) begin
        if (!rst) begin
            int idx;
            idx = -1;
            foreach (pend[i]) if (idx < 0 && pend[i].due <= cyc) idx = i;
            if (idx >= 0) begin
                chk(fire_o == 1'b1, pend[idx].tag, "fire", int'(fire_o), 1);
                chk(fine_o == pend[idx].fine, pend[idx].tag, "fine", int'(fine_o), int'(pend[idx].fine));
                chk(evt_code_o == pend[idx].code, pend[idx].tag, "code", int'(evt_code_o), int'(pend[idx].code));
                pend.delete(idx);
            end else begin
                chk(fire_o == 1'b0, "R11", "unexpected fire", int'(fire_o), 0);
                chk(fine_o == 8'h00 && evt_code_o == 4'h0, "R5", "idle fields",
                    int'({fine_o, evt_code_o}), 0);
            end
            chk(overflow_o == exp_ovf, "R9", "overflow", int'(overflow_o), int'(exp_ovf));
        end
    end

    // driver: offers one event; accepted on the next rising edge
    task automatic issue(input logic [21:0] d, input logic [3:0] c,
                         input logic [7:0] o, input string tag);
        logic [22:0] s;
        int          n_after;
        bit          retire;
        exp_t        e;
        @(negedge clk); #1;
        pat_vld_i  = 1'b1;
        delay_i    = d;
        evt_code_i = c;
        offset_i   = o;
        s = {1'b0, d} + {15'd0, o};
        retire = 1'b0;
        foreach (pend[i]) if (pend[i].due <= cyc + 1) retire = 1'b1;
        n_after = pend.size() - (retire ? 1 : 0);
        if (n_after < 4) begin
            e.due  = cyc + 1 + int'(s[22:8]) + 1;
            e.fine = s[7:0];
            e.code = c;
            e.tag  = tag;
            pend.push_back(e);
        end else begin
            exp_ovf = 1'b1;
        end
        @(posedge clk); #1;
        pat_vld_i = 1'b0;
    endtask

    task automatic noise(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            pat_vld_i  = 1'b0;
            delay_i    = 22'(k * 37);
            evt_code_i = 4'(k + 5);
            offset_i   = 8'(k * 3);
        end
    endtask

    task automatic drain;
        while (pend.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        pat_vld_i = 1'b0;
        pend.delete();
        exp_ovf = 1'b0;
        repeat (3) @(negedge clk);
        chk(fire_o == 1'b0 && overflow_o == 1'b0 && fine_o == 8'h00 && evt_code_o == 4'h0,
            "R1", "reset state", int'({fire_o, overflow_o, fine_o, evt_code_o}), 0);
        #1 rst = 1'b0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk(fire_o == 1'b0 && overflow_o == 1'b0, "R1", "after reset",
            int'({fire_o, overflow_o}), 0);

        // R3: single edge, zero coarse count
        issue(22'h00005A, 4'h3, 8'h00, "R3");
        drain();
        // R3: coarse 5
        issue(22'h000512, 4'h9, 8'h00, "R3");
        drain();
        // R2: offset carries into coarse
        issue(22'h0000F0, 4'h6, 8'h20, "R2");
        drain();

        // R4: all 16 codes back to back
        for (int k = 0; k < 16; k++) issue(22'(k * 11), 4'(k), 8'(k), "R4");
        drain();

        // R8: inputs change with valid low
        noise(12);
        drain();

        // R6: overlapping, out-of-order completion
        issue(22'h000310, 4'h1, 8'h01, "R6");
        issue(22'h000020, 4'h2, 8'h02, "R6");
        issue(22'h000230, 4'h4, 8'h03, "R6");
        issue(22'h000040, 4'h8, 8'h04, "R6");
        drain();

        // R7: two edges due together, then three
        issue(22'h000211, 4'hA, 8'h00, "R7");
        issue(22'h000122, 4'hB, 8'h00, "R7");
        drain();
        issue(22'h000301, 4'hC, 8'h00, "R7");
        issue(22'h000202, 4'hD, 8'h00, "R7");
        issue(22'h000103, 4'hE, 8'h00, "R7");
        drain();

        // R10: arrival on the edge the oldest retires; R9: next is dropped
        issue(22'h000377, 4'h1, 8'h00, "R10");
        issue(22'h001401, 4'h2, 8'h00, "R6");
        issue(22'h001402, 4'h3, 8'h00, "R6");
        issue(22'h001403, 4'h4, 8'h00, "R6");
        issue(22'h000A55, 4'h5, 8'h00, "R10");
        issue(22'h000066, 4'h6, 8'h00, "R9");
        drain();
        chk(overflow_o == 1'b1, "R9", "sticky after drain", int'(overflow_o), 1);

        do_reset();
        // R2: largest delay plus largest offset
        issue(22'h3FFFFF, 4'hF, 8'hFF, "R2");
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule